// File: doc/BRIEF.md
# Connection-Memory Indirect Access Port

This block lets a byte-wide processor bus reach a small internal connection memory through just two register locations. Address select 0 is a read-only status byte. Address select 1 is an access port. A write to the access port is one of three bytes in a fixed transaction: an operation code, then a data byte, then a target address. When the third byte arrives, the block carries out the operation. It either stores the data byte at the target address or copies the addressed word into a readback register. Reads of select 1 return that readback register. A read has no side effects.

An initialization strobe starts a clear engine. The engine writes zero to every memory word, one word per clock, and reports busy for the whole run. An init-request flag is raised at reset and by a clock or power fault input, and a completed clear drops it. Two external controls abandon a half-received transaction: a reset-sequence input, and a run-enable input that is taken low.

Top module: `cmem_indirect_port`

## Requirements
- R1: With bus_sel=0, writes have no effect and bus_rdata shows the status byte. With bus_sel=1, bus_rdata shows the readback register.
- R2: The status byte carries busy at bit 7, init-request at bit 6 and incomplete-transaction at bit 0. Bits 5 to 1 read as zero.
- R3: Writes with bus_sel=1 are taken in the order operation code, data, address. Incomplete reads 1 after the first and second byte and 0 after the third.
- R4: Operation code 0x01 (mode field bits 5:4 = 00, action field bits 1:0 = 01, all other bits 0) stores the data byte at the address given by the third byte.
- R5: Operation code 0x02 (mode 00, action 10) loads the addressed word into the readback register. The new value is visible on bus_rdata with bus_sel=1 from the cycle after the third byte.
- R6: Any other operation code, including one with a nonzero bit in 7, 6, 3 or 2, completes the transaction and changes neither memory nor readback.
- R7: While seq_reset=1 or run_en=0, the transaction position returns to the first byte and incomplete reads 0. Access-port writes in that time are discarded.
- R8: An init_start pulse sampled while idle makes busy read 1 from the next cycle for exactly 2^ADDR_W cycles. Afterwards every memory word reads zero.
- R9: While busy=1, access-port writes and further init_start pulses are ignored.
- R10: Init-request is 1 after reset. A clk_fault pulse sets it from the next cycle. The last clear cycle clears it, unless clk_fault is sampled in that same cycle.
- R11: After reset, busy and incomplete read 0 and the readback register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 status, 1 access port |
| bus_wr | input | 1 | Write strobe, one byte per sampled cycle |
| bus_wdata | input | DATA_W | Write byte |
| bus_rdata | output | DATA_W | Read byte for the selected register |
| seq_reset | input | 1 | Abandon the current transaction while high |
| run_en | input | 1 | Abandon the current transaction while low |
| init_start | input | 1 | Start a full clear of the connection memory |
| clk_fault | input | 1 | Power or clock fault event, raises init-request |

## Verification
The hardest situation to reach is a fault that lands on the very cycle the clear engine retires its last word. In that cycle, the set of the init-request flag and its clear compete. The bench fires a single init pulse, then counts idle cycles from that pulse so that the fault pulse is sampled on exactly the 2^ADDR_W-th busy edge. A transaction byte and a second init pulse are also pushed into the middle of a clear, to show that both leave no trace. A behavioural model follows every edge, and the bench compares the read byte against it on every clock.

// File: rtl/cmem_ip_pkg.sv
package cmem_ip_pkg;

   // Position inside a three-byte transaction on the access port
   typedef enum logic [1:0] {
      SEQ_CTRL = 2'd0,
      SEQ_DATA = 2'd1,
      SEQ_ADDR = 2'd2
   } seq_pos_e;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_LOAD  = 2'd2
   } op_e;

   // Status byte layout
   localparam int unsigned ST_BUSY_BIT   = 7;
   localparam int unsigned ST_INIT_BIT   = 6;
   localparam int unsigned ST_INCOMP_BIT = 0;

   // Full operation codes; every other value is a no-op
   localparam logic [7:0] CODE_WRITE = 8'h01;
   localparam logic [7:0] CODE_LOAD  = 8'h02;

   function automatic op_e decode_code(input logic [7:0] code);
      op_e res;
      unique case (code)
         CODE_WRITE: res = OP_WRITE;
         CODE_LOAD:  res = OP_LOAD;
         default:    res = OP_NONE;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/cmem_ip_seq.sv
module cmem_ip_seq
   import cmem_ip_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cancel,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_byte,
   output logic              incomplete,
   output logic              fire,
   output op_e               op,
   output logic [DATA_W-1:0] data_q,
   output logic [ADDR_W-1:0] addr
);

   seq_pos_e          pos_q;
   logic [DATA_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= SEQ_CTRL;
         code_q <= '0;
         data_q <= '0;
      end else if (cancel) begin
         pos_q <= SEQ_CTRL;
      end else if (wr_stb) begin
         unique case (pos_q)
            SEQ_CTRL: begin
               code_q <= wr_byte;
               pos_q  <= SEQ_DATA;
            end
            SEQ_DATA: begin
               data_q <= wr_byte;
               pos_q  <= SEQ_ADDR;
            end
            default: pos_q <= SEQ_CTRL;
         endcase
      end
   end

   assign incomplete = (pos_q != SEQ_CTRL);
   assign fire       = wr_stb && !cancel && (pos_q == SEQ_ADDR);
   assign op         = decode_code(code_q[7:0]);
   assign addr       = wr_byte[ADDR_W-1:0];

endmodule

// File: rtl/cmem_ip_clear.sv
module cmem_ip_clear #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic [ADDR_W-1:0] ptr,
   output logic              done
);

   localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= '0;
      end else if (busy) begin
         if (ptr == LAST) begin
            busy <= 1'b0;
            ptr  <= '0;
         end else begin
            ptr <= ptr + 1'b1;
         end
      end else if (start) begin
         busy <= 1'b1;
         ptr  <= '0;
      end
   end

   assign done = busy && (ptr == LAST);

endmodule

// File: rtl/cmem_ip_store.sv
module cmem_ip_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk) begin
         if (we && (waddr == ADDR_W'(gi))) begin
            word_q[gi] <= wdata;
         end
      end
   end

   assign rdata = word_q[raddr];

endmodule

// File: rtl/cmem_indirect_port.sv
module cmem_indirect_port
   import cmem_ip_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned CLK_MHZ      = 100,
   parameter int unsigned CLR_LIMIT_US = 250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              seq_reset,
   input  logic              run_en,
   input  logic              init_start,
   input  logic              clk_fault
);

   localparam int unsigned DEPTH      = 1 << ADDR_W;
   localparam int unsigned CLR_BUDGET = CLR_LIMIT_US * CLK_MHZ;

   // Elaboration-time parameter checks
   if (DATA_W != 8) begin : g_bad_width
      $error("cmem_indirect_port: DATA_W must be 8");
   end
   if (ADDR_W > DATA_W || ADDR_W == 0) begin : g_bad_addr
      $error("cmem_indirect_port: ADDR_W must be 1..DATA_W");
   end
   if (DEPTH > CLR_BUDGET) begin : g_bad_time
      $error("cmem_indirect_port: clear run exceeds time budget");
   end

   logic              clr_busy;
   logic              clr_done;
   logic [ADDR_W-1:0] clr_ptr;
   logic              cancel;
   logic              wr_stb;
   logic              seq_incomplete;
   logic              seq_fire;
   op_e               seq_op;
   logic [DATA_W-1:0] seq_data;
   logic [ADDR_W-1:0] seq_addr;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata;
   logic [DATA_W-1:0] rdbk_q;
   logic              init_q;
   logic [DATA_W-1:0] status;

   assign cancel = seq_reset || !run_en;
   assign wr_stb = bus_wr && bus_sel && !clr_busy;

   cmem_ip_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cancel     (cancel),
      .wr_stb     (wr_stb),
      .wr_byte    (bus_wdata),
      .incomplete (seq_incomplete),
      .fire       (seq_fire),
      .op         (seq_op),
      .data_q     (seq_data),
      .addr       (seq_addr)
   );

   cmem_ip_clear #(.ADDR_W(ADDR_W)) u_clear (
      .clk   (clk),
      .rst_n (rst_n),
      .start (init_start),
      .busy  (clr_busy),
      .ptr   (clr_ptr),
      .done  (clr_done)
   );

   // Clear engine owns the write port while busy; the sequencer is gated off then
   assign mem_we    = clr_busy || (seq_fire && seq_op == OP_WRITE);
   assign mem_waddr = clr_busy ? clr_ptr : seq_addr;
   assign mem_wdata = clr_busy ? '0 : seq_data;

   cmem_ip_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (seq_addr),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdbk_q <= '0;
      end else if (seq_fire && seq_op == OP_LOAD) begin
         rdbk_q <= mem_rdata;
      end
   end

   // Init-request: fault wins over a clear finishing in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b1;
      end else if (clk_fault) begin
         init_q <= 1'b1;
      end else if (clr_done) begin
         init_q <= 1'b0;
      end
   end

   for (genvar gb = 0; gb < DATA_W; gb++) begin : g_status
      if (gb == ST_BUSY_BIT) begin : g_b
         assign status[gb] = clr_busy;
      end else if (gb == ST_INIT_BIT) begin : g_r
         assign status[gb] = init_q;
      end else if (gb == ST_INCOMP_BIT) begin : g_z
         assign status[gb] = seq_incomplete;
      end else begin : g_zero
         assign status[gb] = 1'b0;
      end
   end

   assign bus_rdata = bus_sel ? rdbk_q : status;

endmodule

// File: rtl/cmem_ip_chk.sv
module cmem_ip_chk #(
   parameter int unsigned DEPTH = 256
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_sel,
   input logic       bus_wr,
   input logic [7:0] bus_rdata,
   input logic       seq_reset,
   input logic       run_en,
   input logic       init_start,
   input logic       clk_fault,
   input logic       busy,
   input logic       incomplete,
   input logic       init_req
);

   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_run <= 0;
      else if (!busy)  busy_run <= 0;
      else             busy_run <= busy_run + 1;
   end

   AST_CANCEL_CLEARS_Z: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_reset || !run_en) |=> !incomplete);                               // R7

   AST_FIRST_BYTE_SETS_Z: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel && !busy && !seq_reset && run_en && !incomplete)
      |=> incomplete);                                                       // R3

   AST_BUSY_FREEZES_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seq_reset && run_en) |=> $stable(incomplete));               // R9

   AST_FAULT_SETS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      clk_fault |=> init_req);                                               // R10

   AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata[7] == busy && bus_rdata[6] == init_req &&
                    bus_rdata[0] == incomplete && bus_rdata[5:1] == 5'd0));  // R2

   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (init_start && !busy) |=> busy);                                       // R8

   AST_BUSY_WINDOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_run < DEPTH);                                            // R8

   AST_BUSY_WINDOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(busy_run) == DEPTH - 1);                         // R8

endmodule

bind cmem_indirect_port cmem_ip_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_rdata  (bus_rdata),
   .seq_reset  (seq_reset),
   .run_en     (run_en),
   .init_start (init_start),
   .clk_fault  (clk_fault),
   .busy       (clr_busy),
   .incomplete (seq_incomplete),
   .init_req   (init_q)
);

// File: tb/tb_cmem_indirect_port.sv
`timescale 1ns/1ps
module tb_cmem_indirect_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       seq_reset = 1'b0;
   logic       run_en = 1'b1;
   logic       init_start = 1'b0;
   logic       clk_fault = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   cmem_indirect_port dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .seq_reset  (seq_reset),
      .run_en     (run_en),
      .init_start (init_start),
      .clk_fault  (clk_fault)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_mem [256];
   int         m_pos;
   logic [7:0] m_code, m_data, m_rb;
   bit         m_busy, m_init, m_was_busy, m_fin;
   int         m_ptr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_code = 0; m_data = 0; m_rb = 0;
         m_busy = 0; m_init = 1; m_ptr = 0;
      end else begin
         m_was_busy = m_busy;
         m_fin = 0;
         if (seq_reset || !run_en) m_pos = 0;
         else if (bus_wr && bus_sel && !m_was_busy) begin
            if (m_pos == 0) begin m_code = bus_wdata; m_pos = 1; end
            else if (m_pos == 1) begin m_data = bus_wdata; m_pos = 2; end
            else begin
               if (m_code == 8'h01) m_mem[bus_wdata] = m_data;
               else if (m_code == 8'h02) m_rb = m_mem[bus_wdata];
               m_pos = 0;
            end
         end
         if (m_was_busy) begin
            m_mem[m_ptr] = 8'h00;
            if (m_ptr == 255) begin m_busy = 0; m_ptr = 0; m_fin = 1; end
            else m_ptr++;
         end else if (init_start) begin
            m_busy = 1; m_ptr = 0;
         end
         if (clk_fault) m_init = 1;
         else if (m_fin) m_init = 0;
      end
   end

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-clock comparison against the model (R1 select, R2 layout)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (bus_sel) chk(bus_rdata, m_rb, "R1 model readback");
         else chk(bus_rdata, {m_busy, m_init, 5'b0, (m_pos != 0)}, "R2 model status");
      end
   end

   // ---------------- stimulus helpers (start/end just after a posedge) --------
   task automatic wr_byte(input logic s, input logic [7:0] d);
      bus_sel = s; bus_wr = 1'b1; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic s, output logic [7:0] v);
      bus_sel = s;
      @(negedge clk);
      v = bus_rdata;
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic init_pulse();
      init_start = 1'b1;
      @(posedge clk); #1;
      init_start = 1'b0;
   endtask

   task automatic txn(input logic [7:0] c, input logic [7:0] d, input logic [7:0] a);
      wr_byte(1'b1, c); wr_byte(1'b1, d); wr_byte(1'b1, a);
   endtask

   // ---------------- directed scenarios ----------------
   initial begin
      logic [7:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R11 / R10: reset values
      peek(1'b0, v); chk(v, 8'h40, "R11 status after reset (init-request set, R10)");
      peek(1'b1, v); chk(v, 8'h00, "R11 readback after reset");

      // R8 / R10: full clear, busy window, init-request drop
      init_pulse();
      idle(255);
      peek(1'b0, v); chk(v, 8'hC0, "R8 busy on last clear cycle");
      peek(1'b0, v); chk(v, 8'h00, "R8 busy ends, R10 init-request cleared");

      // R8: memory reads zero after clear
      txn(8'h02, 8'h00, 8'h00); peek(1'b1, v); chk(v, 8'h00, "R8 word 0 cleared");
      txn(8'h02, 8'h00, 8'hFF); peek(1'b1, v); chk(v, 8'h00, "R8 word 255 cleared");

      // R3 / R4 / R5: ordered write then load
      wr_byte(1'b1, 8'h01); peek(1'b0, v); chk(v, 8'h01, "R3 incomplete after code byte");
      wr_byte(1'b1, 8'hA5); peek(1'b0, v); chk(v, 8'h01, "R3 incomplete after data byte");
      wr_byte(1'b1, 8'h10); peek(1'b0, v); chk(v, 8'h00, "R3 complete after address byte");
      txn(8'h02, 8'h00, 8'h10);
      bus_sel = 1'b1;
      @(negedge clk); chk(bus_rdata, 8'hA5, "R5 readback next cycle, R4 stored value");
      @(posedge clk); #1;
      txn(8'h01, 8'h3C, 8'hFF); txn(8'h02, 8'h00, 8'hFF);
      peek(1'b1, v); chk(v, 8'h3C, "R4 store at top address");

      // R6: other codes have no effect
      txn(8'h11, 8'h55, 8'h10); peek(1'b0, v); chk(v, 8'h00, "R6 other code completes");
      txn(8'h81, 8'h66, 8'h10); txn(8'h03, 8'h77, 8'h10);
      peek(1'b1, v); chk(v, 8'h3C, "R6 readback untouched");
      txn(8'h42, 8'h00, 8'hFF); peek(1'b1, v); chk(v, 8'h3C, "R6 fixed bit set, no load");
      txn(8'h02, 8'h00, 8'h10); peek(1'b1, v); chk(v, 8'hA5, "R6 memory untouched");

      // R1: writes with select 0 ignored
      wr_byte(1'b0, 8'hFF); peek(1'b0, v); chk(v, 8'h00, "R1 status write ignored");
      peek(1'b1, v); chk(v, 8'hA5, "R1 readback after status write");

      // R7: cancel by seq_reset mid-transaction
      wr_byte(1'b1, 8'h01); wr_byte(1'b1, 8'h99);
      seq_reset = 1'b1; idle(1); seq_reset = 1'b0;
      peek(1'b0, v); chk(v, 8'h00, "R7 seq_reset clears incomplete");
      wr_byte(1'b1, 8'h02); peek(1'b0, v); chk(v, 8'h01, "R7 next byte taken as code");
      wr_byte(1'b1, 8'h00); wr_byte(1'b1, 8'h10);
      peek(1'b1, v); chk(v, 8'hA5, "R7 abandoned write left no trace");

      // R7: run_en low discards writes
      wr_byte(1'b1, 8'h01);
      run_en = 1'b0;
      wr_byte(1'b1, 8'hEE); wr_byte(1'b1, 8'h10);
      peek(1'b0, v); chk(v, 8'h00, "R7 run_en low holds idle");
      run_en = 1'b1;
      txn(8'h02, 8'h00, 8'h10); peek(1'b1, v); chk(v, 8'hA5, "R7 no write under run_en low");

      // R9: writes and init pulses during busy ignored
      init_pulse();
      wr_byte(1'b1, 8'h01);
      init_pulse();
      idle(252);
      peek(1'b0, v); chk(v, 8'h80, "R9 write during busy ignored");
      peek(1'b0, v); chk(v, 8'h80, "R9 still busy on last cycle");
      peek(1'b0, v); chk(v, 8'h00, "R9 second init pulse did not extend busy");

      // R10: fault pulse sets init-request
      clk_fault = 1'b1; idle(1); clk_fault = 1'b0;
      peek(1'b0, v); chk(v, 8'h40, "R10 fault sets init-request");
      // R10: fault on the final clear cycle keeps init-request
      init_pulse();
      idle(255);
      clk_fault = 1'b1; idle(1); clk_fault = 1'b0;
      peek(1'b0, v); chk(v, 8'h40, "R10 fault on last clear cycle wins");
      init_pulse(); idle(256);
      peek(1'b0, v); chk(v, 8'h00, "R10 clean clear drops init-request");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1ms;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule